// File: doc/BRIEF.md
# Toggle-Weighted Power Estimator

This block is a hardware power model attached to one datapath component. It watches the two operand buses of that component and, each time a power strobe rises, samples them. It then forms an estimate of the component's power for that interval: a fixed offset plus, for every operand bit that changed since the last accepted sample, a weight fitted to that bit alone. The weights are fitted offline and written into the block through a simple write port before estimation begins.

To keep area low the weights live in a small synchronous memory, and the sum is built one weight per clock through a single saturating adder instead of a wide adder tree. A finished estimate appears on a 32-bit output with a one-cycle valid pulse and stays there until the next one. A strobe that rises while an estimate is still being built is dropped and flagged.

Top module: `toggle_power_model`

## Requirements
- R1: While reset is high and in the first cycle after it, `pwr_valid`, `overrun` and `pwr_est` are all zero.
- R2: An estimate equals weight 0 plus, for each operand bit whose value differs between the newest and the previous accepted sample, that bit's weight; bit j of `op_a` uses weight j+1 and bit j of `op_b` uses weight A_W+1+j.
- R3: A write with `coef_wr` high stores `coef_wdata` as the weight at `coef_waddr`; later estimates use the new value.
- R4: The first accepted strobe after reset takes the same sample as both newest and previous, so its estimate is weight 0 alone.
- R5: Only a low-to-high change of `pwr_strobe` starts an estimate; a strobe held high yields one result, and `pwr_est` keeps its value in every cycle where `pwr_valid` is low.
- R6: `pwr_valid` is a single-cycle pulse, rising A_W+B_W+2 clock edges after the edge at which the strobe rise is accepted.
- R7: A strobe rise that arrives while an estimate is being built sets `overrun`, starts nothing and leaves the stored samples unchanged; the next accepted strobe clears `overrun`.
- R8: The sum is unsigned and sticks at 32'hFFFF_FFFF instead of wrapping when it exceeds 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_strobe | input | 1 | Sampling strobe; its rising change starts an estimate |
| op_a | input | A_W | First monitored operand |
| op_b | input | B_W | Second monitored operand |
| coef_wr | input | 1 | Weight write enable |
| coef_waddr | input | ADDR_W | Weight index to write |
| coef_wdata | input | C_W | Weight value |
| pwr_est | output | C_W | Latest power estimate |
| pwr_valid | output | 1 | One-cycle pulse marking a new estimate |
| overrun | output | 1 | A strobe was dropped because an estimate was in progress |

## Verification
The hardest case to reach is a strobe rise landing inside the multi-cycle build window, because the block must drop it without touching its stored samples. The stimulus accepts one strobe, lowers the strobe, and raises it again a few cycles later with different operands while the first estimate is still running; it then checks the flag and issues a further strobe whose expected value is computed against the samples from before the dropped one, so any disturbed sample shows up as a wrong estimate. Saturation is reached by loading large weights and toggling every bit at once.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  // Sequencer states of the weight walk
  typedef enum logic [1:0] {
    TPM_IDLE  = 2'd0,
    TPM_RUN   = 2'd1,
    TPM_DRAIN = 2'd2
  } tpm_state_e;

endpackage

// File: rtl/tpm_coef_ram.sv
// Simple dual-port weight store: one write port, one registered read port.
module tpm_coef_ram #(
  parameter int DEPTH  = 33,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (int'(raddr) < DEPTH) begin
      rdata <= mem[raddr];
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/tpm_sampler.sv
// Strobe edge detection, operand sample pair, toggle vector and overrun flag.
module tpm_sampler #(
  parameter int NB = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [NB-1:0] ops,
  input  logic          busy,
  output logic          start,
  output logic [NB-1:0] toggles,
  output logic          overrun
);

  logic          strb_q;
  logic          first_q;
  logic [NB-1:0] cur_q;
  logic [NB-1:0] prv_q;
  logic          rise;

  assign rise    = strobe && !strb_q;
  assign start   = rise && !busy;
  assign toggles = cur_q ^ prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q  <= 1'b0;
      first_q <= 1'b1;
      cur_q   <= '0;
      prv_q   <= '0;
      overrun <= 1'b0;
    end else begin
      strb_q <= strobe;
      if (start) begin
        cur_q   <= ops;
        prv_q   <= first_q ? ops : cur_q;
        first_q <= 1'b0;
        overrun <= 1'b0;
      end else if (rise) begin
        overrun <= 1'b1;
      end
    end
  end

  AST_DROP_KEEPS_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    (rise && busy) |=> ($stable(cur_q) && $stable(prv_q) && overrun)); // R7

  AST_FIRST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (start && first_q) |=> (cur_q == prv_q)); // R4

endmodule

// File: rtl/tpm_accum.sv
// Gated, saturating accumulation of weights and the registered result.
module tpm_accum #(
  parameter int NB     = 32,
  parameter int C_W    = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              vld,
  input  logic [ADDR_W-1:0] idx,
  input  logic [C_W-1:0]    coef,
  input  logic [NB-1:0]     toggles,
  output logic              last,
  output logic [C_W-1:0]    pwr_est,
  output logic              pwr_valid
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NB);

  logic [NB:0]    gate_vec;
  logic [C_W-1:0] acc_q;
  logic [C_W-1:0] term;
  logic [C_W:0]   wide_sum;
  logic [C_W-1:0] sat_sum;

  // Index 0 is the constant weight and is always taken.
  assign gate_vec = {toggles, 1'b1};
  assign term     = gate_vec[idx] ? coef : '0;
  assign wide_sum = {1'b0, acc_q} + {1'b0, term};
  assign sat_sum  = wide_sum[C_W] ? {C_W{1'b1}} : wide_sum[C_W-1:0];
  assign last     = vld && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      pwr_est   <= '0;
      pwr_valid <= 1'b0;
    end else begin
      pwr_valid <= 1'b0;
      if (clr) begin
        acc_q <= '0;
      end else if (vld) begin
        acc_q <= sat_sum;
        if (last) begin
          pwr_est   <= sat_sum;
          pwr_valid <= 1'b1;
        end
      end
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (vld && !clr && (acc_q == {C_W{1'b1}})) |=> (acc_q == {C_W{1'b1}})); // R8

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pwr_valid |=> !pwr_valid); // R6

endmodule

// File: rtl/toggle_power_model.sv
module toggle_power_model
  import tpm_pkg::*;
#(
  parameter  int A_W    = 16,
  parameter  int B_W    = 16,
  parameter  int C_W    = 32,
  localparam int NB     = A_W + B_W,
  localparam int ADDR_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_strobe,
  input  logic [A_W-1:0]    op_a,
  input  logic [B_W-1:0]    op_b,
  input  logic              coef_wr,
  input  logic [ADDR_W-1:0] coef_waddr,
  input  logic [C_W-1:0]    coef_wdata,
  output logic [C_W-1:0]    pwr_est,
  output logic              pwr_valid,
  output logic              overrun
);

  localparam int                DEPTH    = NB + 1;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NB);

  tpm_state_e        state;
  logic [ADDR_W-1:0] rd_idx;
  logic [ADDR_W-1:0] idx_q;
  logic              iss_q;
  logic              busy;
  logic              start;
  logic              last;
  logic [NB-1:0]     toggles;
  logic [C_W-1:0]    coef;

  assign busy = (state != TPM_IDLE);

  tpm_sampler #(.NB(NB)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .strobe  (pwr_strobe),
    .ops     ({op_b, op_a}),
    .busy    (busy),
    .start   (start),
    .toggles (toggles),
    .overrun (overrun)
  );

  tpm_coef_ram #(.DEPTH(DEPTH), .DATA_W(C_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (coef_wr),
    .waddr (coef_waddr),
    .wdata (coef_wdata),
    .raddr (rd_idx),
    .rdata (coef)
  );

  // Walk one weight address per clock; the read data arrives a cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TPM_IDLE;
      rd_idx <= '0;
      idx_q  <= '0;
      iss_q  <= 1'b0;
    end else begin
      iss_q <= (state == TPM_RUN);
      idx_q <= rd_idx;
      case (state)
        TPM_IDLE: begin
          if (start) begin
            state  <= TPM_RUN;
            rd_idx <= '0;
          end
        end
        TPM_RUN: begin
          if (rd_idx == LAST_IDX) begin
            state <= TPM_DRAIN;
          end else begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        TPM_DRAIN: begin
          if (last) begin
            state <= TPM_IDLE;
          end
        end
        default: state <= TPM_IDLE;
      endcase
    end
  end

  tpm_accum #(.NB(NB), .C_W(C_W), .ADDR_W(ADDR_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .vld       (iss_q),
    .idx       (idx_q),
    .coef      (coef),
    .toggles   (toggles),
    .last      (last),
    .pwr_est   (pwr_est),
    .pwr_valid (pwr_valid)
  );

  AST_HOLD_EST: assert property (@(posedge clk) disable iff (rst)
    !pwr_valid |-> $stable(pwr_est)); // R5

  AST_RESULT_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_valid) |-> (state == TPM_IDLE)); // R6

endmodule

// File: tb/toggle_power_model_tb.sv
`timescale 1ns/1ps
module toggle_power_model_tb;

  localparam int A_W = 16;
  localparam int B_W = 16;
  localparam int NB  = A_W + B_W;
  localparam int AW  = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_strobe = 1'b0;
  logic [15:0]   op_a = '0;
  logic [15:0]   op_b = '0;
  logic          coef_wr = 1'b0;
  logic [AW-1:0] coef_waddr = '0;
  logic [31:0]   coef_wdata = '0;
  logic [31:0]   pwr_est;
  logic          pwr_valid;
  logic          overrun;

  int total = 0;
  int bad   = 0;

  logic [31:0] cf [NB+1];
  logic [31:0] m_cur, m_prv;
  bit          m_first = 1'b1;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  toggle_power_model u_dut (
    .clk(clk), .rst(rst), .pwr_strobe(pwr_strobe), .op_a(op_a), .op_b(op_b),
    .coef_wr(coef_wr), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
    .pwr_est(pwr_est), .pwr_valid(pwr_valid), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference estimate from the weight rule, independent of the design
  function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] p);
    logic [63:0] s = {32'd0, cf[0]};
    for (int j = 0; j < NB; j++) begin
      if (c[j] != p[j]) s += {32'd0, cf[j+1]};
    end
    return (s > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  task automatic push(input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [31:0] smp = {b, a};
    m_prv   = m_first ? smp : m_cur;
    m_cur   = smp;
    m_first = 1'b0;
    exp_q.push_back(model(m_cur, m_prv));
    tag_q.push_back(tag);
  endtask

  task automatic wr_coef(input int i, input logic [31:0] v);
    @(negedge clk);
    coef_wr = 1'b1; coef_waddr = AW'(i); coef_wdata = v; cf[i] = v;
    @(negedge clk);
    coef_wr = 1'b0;
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!pwr_valid) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // Accepted strobe: drive, expect, and check latency and pulse width (R6)
  task automatic run(input logic [15:0] a, input logic [15:0] b, input string tag);
    int lat;
    @(negedge clk);
    op_a = a; op_b = b; pwr_strobe = 1'b1;
    push(a, b, tag);
    @(negedge clk);
    pwr_strobe = 1'b0;
    wait_valid(lat);
    chk("R6 latency", 32'(lat), 32'(NB + 2));
    @(negedge clk);
    chk("R6 pulse width", {31'd0, pwr_valid}, 32'd0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pwr_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 unexpected result act=%h exp=none", pwr_est);
      end else begin
        chk(tag_q.pop_front(), pwr_est, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] hold;
    int          lat;

    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, pwr_valid}, 32'd0);
    chk("R1 reset est", pwr_est, 32'd0);
    chk("R1 reset overrun", {31'd0, overrun}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset est", pwr_est, 32'd0);

    for (int i = 0; i <= NB; i++) wr_coef(i, 32'h100 * (i + 1) + i);

    run(16'h1234, 16'hABCD, "R4 first strobe");
    run(16'h1235, 16'hABCD, "R2 op_a bit0");
    run(16'h9235, 16'hABCD, "R2 op_a bit15");
    run(16'h9235, 16'hABCC, "R2 op_b bit0");
    run(16'h9235, 16'h2BCC, "R2 op_b bit15");

    lf = 32'hACE1_1234;
    for (int k = 0; k < 6; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(lf[15:0], lf[31:16], "R2 pattern");
    end

    // R5: strobe held high gives a single result, output then holds
    @(negedge clk);
    op_a = 16'h0F0F; op_b = 16'hF0F0; pwr_strobe = 1'b1;
    push(16'h0F0F, 16'hF0F0, "R5 held strobe");
    @(negedge clk);
    wait_valid(lat);
    @(negedge clk);
    hold = pwr_est;
    repeat (20) @(negedge clk);
    chk("R5 output held", pwr_est, hold);
    pwr_strobe = 1'b0;

    // R7: strobe during a running estimate is dropped
    @(negedge clk);
    op_a = 16'h1111; op_b = 16'h2222; pwr_strobe = 1'b1;
    push(16'h1111, 16'h2222, "R7 accepted before drop");
    @(negedge clk);
    pwr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    op_a = 16'hFFFF; op_b = 16'h0000; pwr_strobe = 1'b1;
    @(negedge clk);
    pwr_strobe = 1'b0;
    chk("R7 overrun set", {31'd0, overrun}, 32'd1);
    wait_valid(lat);
    @(negedge clk);
    run(16'h1113, 16'h2222, "R7 samples kept");
    chk("R7 overrun cleared", {31'd0, overrun}, 32'd0);

    // R3: rewritten weight takes effect
    wr_coef(3, 32'hDEAD_0000);
    run(16'h1117, 16'h2222, "R3 new weight");

    // R8: saturation
    for (int i = 0; i <= NB; i++) wr_coef(i, 32'h2000_0000);
    run(16'h1114, 16'h2222, "R8 below limit");
    run(16'hEEEB, 16'hDDDD, "R8 saturate");

    repeat (5) @(negedge clk);
    chk("R5 no missing result", 32'(exp_q.size()), 32'd0);
    summary();
  end

endmodule